// File: doc/BRIEF.md
# Paired Register File with Move Decode

This block is the general-register bank of an 8-bit processor core. It holds seven byte registers (the accumulator plus six working registers). Three pairs of these registers can also be used as 16-bit registers. The block decodes register-to-register move opcodes directly from the opcode byte and completes each move in one clock. It also carries out 16-bit pair commands: immediate load, exchange of the address pair with the data pair, increment, decrement, and a copy-out of the address pair for loading a stack pointer. The bus interface, the arithmetic unit and instruction fetch are outside this block. The block reports a memory-operand move to them and does not perform it.

Each cycle the decoder reduces its inputs to one action, checking them in priority order. A valid move opcode comes first. A pair command comes next, and a single-byte write comes last. The actions are IDLE, MOVE, MEM (a move whose operand is memory), LOAD16, XCHG, INC16, DEC16, SPCOPY and WR8. Every register update takes effect on the rising clock edge. Read ports, the memory-address output and the request strobes are combinational.

Top module: `pair_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register to 00h at the rising edge, so all read ports and `hl_addr` show zero afterwards.
- R2: With `op_valid` high, an opcode of binary form 01 ddd sss copies register sss into register ddd at the next rising edge and leaves the source unchanged. The register codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111, so opcode 78h copies B into A.
- R3: A valid move opcode whose ddd or sss field is 110 (memory) raises `mem_req` in the same cycle and writes no register. `mem_wr` is high in that cycle exactly when ddd is 110.
- R4: With `op_valid` high, an opcode whose top two bits are not 01 changes no register and raises no request. With `op_valid` low, the opcode byte is ignored.
- R5: Pair command 001 (LOAD16) writes `wdata16[15:8]` to the high register and `wdata16[7:0]` to the low register of the selected pair. The pair codes are 00=B-C, 01=D-E and 10=H-L. Pair code 11 is ignored.
- R6: Pair command 010 (XCHG) swaps the full 16-bit contents of H-L and D-E at one edge, whatever the pair select.
- R7: Pair command 011 (INC16) adds one to the selected 16-bit pair, carrying from the low byte into the high byte, and wraps FFFFh to 0000h.
- R8: Pair command 100 (DEC16) subtracts one from the selected 16-bit pair, borrowing from the high byte, and wraps 0000h to FFFFh.
- R9: `hl_addr` always equals the H-L pair, with H as the high byte.
- R10: Pair command 101 (SPCOPY) with pair code 10 raises `sp_load` in the same cycle with `sp_data` equal to H-L and changes no register. With any other pair code, `sp_load` stays low.
- R11: With `wr8_en` high, `wdata8` is written to the register named by `wr8_sel` at the next edge. Code 110 is ignored.
- R12: When several commands arrive in one cycle, only one is carried out. A valid move opcode, including a memory move, comes first. A pair command other than 000 comes second, and the byte write comes last.
- R13: `rd_a`, `rd_b` and `rd_pair` show the current register contents without delay. Byte code 110 reads 00h, and pair code 11 reads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode strobe |
| op_byte | input | 8 | Opcode byte |
| pair_cmd | input | 3 | Pair command (000 none, 001 load, 010 exchange, 011 inc, 100 dec, 101 stack copy) |
| pair_sel | input | 2 | Pair select for pair commands |
| wdata16 | input | 16 | Immediate data for LOAD16 |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 3 | Byte write register code |
| wdata8 | input | 8 | Byte write data |
| rd_sel_a | input | 3 | Read port A register code |
| rd_a | output | 8 | Read port A data |
| rd_sel_b | input | 3 | Read port B register code |
| rd_b | output | 8 | Read port B data |
| rd_pair_sel | input | 2 | Pair read select |
| rd_pair | output | 16 | Pair read data |
| hl_addr | output | 16 | H-L pair as memory address |
| mem_req | output | 1 | Memory-operand move seen this cycle |
| mem_wr | output | 1 | That move targets memory |
| sp_load | output | 1 | Stack-pointer copy strobe |
| sp_data | output | 16 | Value to copy into the stack pointer |

## Verification
The results of moves, pair loads, exchanges, increments, decrements and byte writes appear one rising edge after the command is applied. The bench drives each command at a falling edge and reads the register ports at the next falling edge, after exactly one update. `mem_req`, `mem_wr`, `sp_load`, `sp_data` and the read ports respond in the same cycle as their inputs, so the bench samples them 1 ns after driving and before the edge. The next falling edge then confirms that no register moved. A reference model in the bench is updated from the requirements alone, and every register is compared after each scenario step.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam logic [2:0] CODE_B   = 3'b000;
    localparam logic [2:0] CODE_C   = 3'b001;
    localparam logic [2:0] CODE_D   = 3'b010;
    localparam logic [2:0] CODE_E   = 3'b011;
    localparam logic [2:0] CODE_H   = 3'b100;
    localparam logic [2:0] CODE_L   = 3'b101;
    localparam logic [2:0] CODE_MEM = 3'b110;
    localparam logic [2:0] CODE_A   = 3'b111;

    localparam logic [1:0] PAIR_BC  = 2'b00;
    localparam logic [1:0] PAIR_DE  = 2'b01;
    localparam logic [1:0] PAIR_HL  = 2'b10;
    localparam logic [1:0] PAIR_NONE = 2'b11;

    localparam logic [1:0] MOVE_GROUP = 2'b01;

    typedef enum logic [2:0] {
        PC_NONE   = 3'b000,
        PC_LOAD   = 3'b001,
        PC_XCHG   = 3'b010,
        PC_INC    = 3'b011,
        PC_DEC    = 3'b100,
        PC_SPCOPY = 3'b101
    } pcmd_e;

    typedef enum logic [3:0] {
        ACT_IDLE,
        ACT_MOVE,
        ACT_MEM,
        ACT_LOAD16,
        ACT_XCHG,
        ACT_INC16,
        ACT_DEC16,
        ACT_SPCOPY,
        ACT_WR8
    } act_e;

endpackage

// File: rtl/rb_decode.sv
module rb_decode
    import rb_pkg::*;
#(
    parameter int CW = 3,
    parameter int PSW = 2
) (
    input  logic           op_valid,
    input  logic [7:0]     op_byte,
    input  logic [2:0]     pair_cmd,
    input  logic [PSW-1:0] pair_sel,
    input  logic           wr8_en,
    input  logic [CW-1:0]  wr8_sel,
    output act_e           act,
    output logic [CW-1:0]  dst,
    output logic [CW-1:0]  src
);

    logic is_move;
    logic uses_mem;

    assign dst      = op_byte[5:3];
    assign src      = op_byte[2:0];
    assign is_move  = op_valid && (op_byte[7:6] == MOVE_GROUP);
    assign uses_mem = (dst == CODE_MEM) || (src == CODE_MEM);

    always_comb begin
        act = ACT_IDLE;
        if (is_move) begin
            act = uses_mem ? ACT_MEM : ACT_MOVE;
        end else begin
            unique case (pcmd_e'(pair_cmd))
                PC_LOAD:   act = (pair_sel != PAIR_NONE) ? ACT_LOAD16 : ACT_IDLE;
                PC_XCHG:   act = ACT_XCHG;
                PC_INC:    act = (pair_sel != PAIR_NONE) ? ACT_INC16 : ACT_IDLE;
                PC_DEC:    act = (pair_sel != PAIR_NONE) ? ACT_DEC16 : ACT_IDLE;
                PC_SPCOPY: act = (pair_sel == PAIR_HL) ? ACT_SPCOPY : ACT_IDLE;
                default:   act = ACT_IDLE;
            endcase
            if (pair_cmd == PC_NONE && wr8_en && wr8_sel != CODE_MEM) begin
                act = ACT_WR8;
            end
        end
    end

endmodule

// File: rtl/rb_incdec.sv
module rb_incdec #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (down) nxt = val - ONE;
        else      nxt = val + ONE;
    end

endmodule

// File: rtl/rb_cells.sv
module rb_cells #(
    parameter int DW = 8,
    parameter int NREG = 8,
    parameter int HOLE = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NREG-1:0]          wen,
    input  logic [NREG-1:0][DW-1:0]  wval,
    output logic [NREG-1:0][DW-1:0]  q
);

    for (genvar i = 0; i < NREG; i++) begin : g_cell
        if (i == HOLE) begin : g_hole
            assign q[i] = '0;
        end else begin : g_reg
            logic [DW-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)         r <= '0;
                else if (wen[i]) r <= wval[i];
            end
            assign q[i] = r;
        end
    end

endmodule

// File: rtl/pair_regbank.sv
module pair_regbank
    import rb_pkg::*;
#(
    parameter int DW  = 8,
    parameter int CW  = 3,
    parameter int PSW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic [2:0]        pair_cmd,
    input  logic [PSW-1:0]    pair_sel,
    input  logic [2*DW-1:0]   wdata16,
    input  logic              wr8_en,
    input  logic [CW-1:0]     wr8_sel,
    input  logic [DW-1:0]     wdata8,
    input  logic [CW-1:0]     rd_sel_a,
    output logic [DW-1:0]     rd_a,
    input  logic [CW-1:0]     rd_sel_b,
    output logic [DW-1:0]     rd_b,
    input  logic [PSW-1:0]    rd_pair_sel,
    output logic [2*DW-1:0]   rd_pair,
    output logic [2*DW-1:0]   hl_addr,
    output logic              mem_req,
    output logic              mem_wr,
    output logic              sp_load,
    output logic [2*DW-1:0]   sp_data
);

    localparam int NREG = 1 << CW;
    localparam int PW   = 2 * DW;

    act_e                   act;
    logic [CW-1:0]          dst;
    logic [CW-1:0]          src;
    logic [NREG-1:0]        wen;
    logic [NREG-1:0][DW-1:0] wval;
    logic [NREG-1:0][DW-1:0] q;
    logic [PW-1:0]          pair_cur;
    logic [PW-1:0]          pair_nxt;
    logic [CW-1:0]          hi_idx;
    logic [CW-1:0]          lo_idx;

    rb_decode #(.CW(CW), .PSW(PSW)) u_dec (
        .op_valid (op_valid),
        .op_byte  (op_byte),
        .pair_cmd (pair_cmd),
        .pair_sel (pair_sel),
        .wr8_en   (wr8_en),
        .wr8_sel  (wr8_sel),
        .act      (act),
        .dst      (dst),
        .src      (src)
    );

    assign hi_idx   = {pair_sel, 1'b0};
    assign lo_idx   = {pair_sel, 1'b1};
    assign pair_cur = {q[hi_idx], q[lo_idx]};

    rb_incdec #(.W(PW)) u_step (
        .val  (pair_cur),
        .down (act == ACT_DEC16),
        .nxt  (pair_nxt)
    );

    always_comb begin
        wen  = '0;
        wval = '0;
        unique case (act)
            ACT_MOVE: begin
                wen[dst]  = 1'b1;
                wval[dst] = q[src];
            end
            ACT_LOAD16: begin
                wen[hi_idx]  = 1'b1;
                wval[hi_idx] = wdata16[PW-1:DW];
                wen[lo_idx]  = 1'b1;
                wval[lo_idx] = wdata16[DW-1:0];
            end
            ACT_XCHG: begin
                wen[CODE_H]  = 1'b1;
                wval[CODE_H] = q[CODE_D];
                wen[CODE_L]  = 1'b1;
                wval[CODE_L] = q[CODE_E];
                wen[CODE_D]  = 1'b1;
                wval[CODE_D] = q[CODE_H];
                wen[CODE_E]  = 1'b1;
                wval[CODE_E] = q[CODE_L];
            end
            ACT_INC16, ACT_DEC16: begin
                wen[hi_idx]  = 1'b1;
                wval[hi_idx] = pair_nxt[PW-1:DW];
                wen[lo_idx]  = 1'b1;
                wval[lo_idx] = pair_nxt[DW-1:0];
            end
            ACT_WR8: begin
                wen[wr8_sel]  = 1'b1;
                wval[wr8_sel] = wdata8;
            end
            default: begin
                wen  = '0;
                wval = '0;
            end
        endcase
    end

    rb_cells #(.DW(DW), .NREG(NREG), .HOLE(int'(CODE_MEM))) u_cells (
        .clk  (clk),
        .rst  (rst),
        .wen  (wen),
        .wval (wval),
        .q    (q)
    );

    always_comb begin
        rd_a    = q[rd_sel_a];
        rd_b    = q[rd_sel_b];
        hl_addr = {q[CODE_H], q[CODE_L]};
        rd_pair = (rd_pair_sel == PAIR_NONE) ? '0
                : {q[{rd_pair_sel, 1'b0}], q[{rd_pair_sel, 1'b1}]};
        mem_req = (act == ACT_MEM);
        mem_wr  = (act == ACT_MEM) && (dst == CODE_MEM);
        sp_load = (act == ACT_SPCOPY);
        sp_data = {q[CODE_H], q[CODE_L]};
    end

endmodule

// File: rtl/rb_chk.sv
module rb_chk #(
    parameter int DW = 8,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_valid,
    input  logic [7:0]              op_byte,
    input  logic [2:0]              pair_cmd,
    input  logic [1:0]              pair_sel,
    input  logic [2*DW-1:0]         hl_addr,
    input  logic                    mem_req,
    input  logic                    sp_load,
    input  logic [2*DW-1:0]         sp_data,
    input  logic [NREG-1:0][DW-1:0] q
);

    logic          mv;
    logic [2*DW-1:0] de;

    assign mv = op_valid && (op_byte[7:6] == 2'b01);
    assign de = {q[2], q[3]};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (q == '0)); // R1

    AST_MOVE_COPY: assert property (@(posedge clk) disable iff (rst)
        (mv && op_byte[5:3] != 3'b110 && op_byte[2:0] != 3'b110)
        |=> q[$past(op_byte[5:3])] == $past(q[op_byte[2:0]])); // R2

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> $stable(q)); // R3

    AST_XCHG_SWAP: assert property (@(posedge clk) disable iff (rst)
        (!mv && pair_cmd == 3'b010)
        |=> (hl_addr == $past(de)) && (de == $past(hl_addr))); // R6

    AST_INC_HL: assert property (@(posedge clk) disable iff (rst)
        (!mv && pair_cmd == 3'b011 && pair_sel == 2'b10)
        |=> hl_addr == $past(hl_addr) + 1'b1); // R7

    AST_DEC_HL: assert property (@(posedge clk) disable iff (rst)
        (!mv && pair_cmd == 3'b100 && pair_sel == 2'b10)
        |=> hl_addr == $past(hl_addr) - 1'b1); // R8

    AST_SP_COPY: assert property (@(posedge clk) disable iff (rst)
        sp_load |-> (sp_data == hl_addr) && (pair_sel == 2'b10)); // R10

endmodule

bind pair_regbank rb_chk #(.DW(DW), .NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_byte  (op_byte),
    .pair_cmd (pair_cmd),
    .pair_sel (pair_sel),
    .hl_addr  (hl_addr),
    .mem_req  (mem_req),
    .sp_load  (sp_load),
    .sp_data  (sp_data),
    .q        (q)
);

// File: tb/sim_pair_regbank.sv
module sim_pair_regbank;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [7:0]  op_byte;
    logic [2:0]  pair_cmd;
    logic [1:0]  pair_sel;
    logic [15:0] wdata16;
    logic        wr8_en;
    logic [2:0]  wr8_sel;
    logic [7:0]  wdata8;
    logic [2:0]  rd_sel_a;
    logic [7:0]  rd_a;
    logic [2:0]  rd_sel_b;
    logic [7:0]  rd_b;
    logic [1:0]  rd_pair_sel;
    logic [15:0] rd_pair;
    logic [15:0] hl_addr;
    logic        mem_req;
    logic        mem_wr;
    logic        sp_load;
    logic [15:0] sp_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] m [8];

    always #4 clk = ~clk;

    pair_regbank u0 (.*);

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic quiet();
        op_valid = 0; op_byte = 8'h00; pair_cmd = 3'b000; pair_sel = 2'b00;
        wdata16 = 16'h0; wr8_en = 0; wr8_sel = 3'b000; wdata8 = 8'h0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        quiet();
    endtask

    task automatic check_regs(input string req);
        for (int c = 0; c < 8; c++) begin
            rd_sel_a = 3'(c);
            #1;
            chk(req, {8'h00, rd_a}, {8'h00, m[c]});
        end
        chk(req, hl_addr, {m[4], m[5]});
    endtask

    task automatic load16(input logic [1:0] p, input logic [15:0] v);
        pair_cmd = 3'b001; pair_sel = p; wdata16 = v;
        cyc();
        if (p != 2'b11) begin
            m[{p, 1'b0}] = v[15:8];
            m[{p, 1'b1}] = v[7:0];
        end
    endtask

    task automatic t_reset();
        quiet();
        rst = 1;
        rd_sel_a = 0; rd_sel_b = 0; rd_pair_sel = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        for (int c = 0; c < 8; c++) m[c] = 8'h00;
        check_regs("R1");
    endtask

    task automatic t_load();
        load16(2'b00, 16'h1234);
        load16(2'b01, 16'h5678);
        load16(2'b10, 16'h9ABC);
        check_regs("R5");
        chk("R9", hl_addr, 16'h9ABC);
        rd_pair_sel = 2'b01; #1;
        chk("R13", rd_pair, 16'h5678);
        rd_pair_sel = 2'b11; #1;
        chk("R13", rd_pair, 16'h0000);
        load16(2'b11, 16'hFFFF);
        check_regs("R5");
    endtask

    task automatic t_move();
        op_valid = 1; op_byte = 8'h78;
        cyc();
        m[7] = m[0];
        check_regs("R2");
        op_valid = 1; op_byte = 8'h4D;
        cyc();
        m[1] = m[5];
        check_regs("R2");
        op_valid = 1; op_byte = 8'h63;
        cyc();
        m[4] = m[3];
        check_regs("R2");
        chk("R9", hl_addr, {m[4], m[5]});
    endtask

    task automatic t_mem();
        op_valid = 1; op_byte = 8'h70;
        #1;
        chk("R3", {14'h0, mem_req, mem_wr}, 16'h0003);
        cyc();
        check_regs("R3");
        op_valid = 1; op_byte = 8'h46;
        #1;
        chk("R3", {14'h0, mem_req, mem_wr}, 16'h0002);
        cyc();
        check_regs("R3");
        op_valid = 1; op_byte = 8'h76;
        #1;
        chk("R3", {14'h0, mem_req, mem_wr}, 16'h0003);
        cyc();
        check_regs("R3");
    endtask

    task automatic t_ignore();
        op_valid = 1; op_byte = 8'h80;
        #1; chk("R4", {15'h0, mem_req}, 16'h0);
        cyc();
        op_valid = 1; op_byte = 8'hC7;
        cyc();
        op_valid = 0; op_byte = 8'h78;
        cyc();
        op_valid = 0; op_byte = 8'h70;
        #1; chk("R4", {15'h0, mem_req}, 16'h0);
        cyc();
        check_regs("R4");
    endtask

    task automatic t_xchg();
        logic [7:0] th, tl;
        pair_cmd = 3'b010; pair_sel = 2'b00;
        cyc();
        th = m[4]; tl = m[5];
        m[4] = m[2]; m[5] = m[3]; m[2] = th; m[3] = tl;
        check_regs("R6");
    endtask

    task automatic t_incdec();
        load16(2'b00, 16'hFFFF);
        pair_cmd = 3'b011; pair_sel = 2'b00; cyc();
        m[0] = 8'h00; m[1] = 8'h00;
        check_regs("R7");
        pair_cmd = 3'b100; pair_sel = 2'b00; cyc();
        m[0] = 8'hFF; m[1] = 8'hFF;
        check_regs("R8");
        load16(2'b01, 16'h00FF);
        pair_cmd = 3'b011; pair_sel = 2'b01; cyc();
        m[2] = 8'h01; m[3] = 8'h00;
        check_regs("R7");
        load16(2'b10, 16'h0000);
        pair_cmd = 3'b100; pair_sel = 2'b10; cyc();
        m[4] = 8'hFF; m[5] = 8'hFF;
        check_regs("R8");
        load16(2'b10, 16'h1200);
        pair_cmd = 3'b100; pair_sel = 2'b10; cyc();
        m[4] = 8'h11; m[5] = 8'hFF;
        check_regs("R8");
    endtask

    task automatic t_sp();
        pair_cmd = 3'b101; pair_sel = 2'b10;
        #1;
        chk("R10", {15'h0, sp_load}, 16'h1);
        chk("R10", sp_data, {m[4], m[5]});
        cyc();
        pair_cmd = 3'b101; pair_sel = 2'b01;
        #1;
        chk("R10", {15'h0, sp_load}, 16'h0);
        cyc();
        check_regs("R10");
    endtask

    task automatic t_wr8();
        wr8_en = 1; wr8_sel = 3'b111; wdata8 = 8'h5A;
        cyc();
        m[7] = 8'h5A;
        check_regs("R11");
        wr8_en = 1; wr8_sel = 3'b110; wdata8 = 8'hA5;
        cyc();
        check_regs("R11");
        rd_sel_b = 3'b110; #1;
        chk("R13", {8'h0, rd_b}, 16'h0000);
        rd_sel_b = 3'b111; #1;
        chk("R13", {8'h0, rd_b}, 16'h005A);
    endtask

    task automatic t_prio();
        op_valid = 1; op_byte = 8'h41;
        pair_cmd = 3'b011; pair_sel = 2'b10;
        wr8_en = 1; wr8_sel = 3'b010; wdata8 = 8'h99;
        cyc();
        m[0] = m[1];
        check_regs("R12");
        pair_cmd = 3'b011; pair_sel = 2'b01;
        wr8_en = 1; wr8_sel = 3'b111; wdata8 = 8'h33;
        cyc();
        {m[2], m[3]} = {m[2], m[3]} + 16'h1;
        check_regs("R12");
        op_valid = 1; op_byte = 8'h77;
        pair_cmd = 3'b001; pair_sel = 2'b00; wdata16 = 16'hDEAD;
        wr8_en = 1; wr8_sel = 3'b000; wdata8 = 8'h11;
        cyc();
        check_regs("R12");
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        t_reset();
        t_load();
        t_move();
        t_mem();
        t_ignore();
        t_xchg();
        t_incdec();
        t_sp();
        t_wr8();
        t_prio();
        rst = 1;
        cyc();
        rst = 0;
        for (int c = 0; c < 8; c++) m[c] = 8'h00;
        check_regs("R1");
        report();
    end

endmodule